// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block holds two timers for a small microcontroller subsystem. Each timer keeps its count in a low byte and a high byte. A shared mode register holds one 4-bit field per timer, and a shared control register holds a run bit and an overflow flag for each timer. On every cycle in which the machine-cycle strobe `tick` is high, each enabled timer advances by one in the counting mode its field selects. When a timer wraps past its top value, it raises its overflow flag. The flag stays set until it is cleared.

All six registers are written one byte at a time through a simple write port and read back through a combinational read port. The interrupt controller clears a flag with a one-cycle pulse on `ovf_clr`. Only internal counting is supported: a timer whose gate bit or external-select bit is set holds its value. The bus is a plain register port with no back-pressure. A write always completes in the cycle it is presented.

Top module: `tmr_dual`

## Requirements
- R1: After reset, every register reads 0x00 and both `ovf_flag` pins are 0.
- R2: `rd_sel`/`wr_sel` codes: 0 low0, 1 high0, 2 low1, 3 high1, 4 mode, 5 control. In the control byte only bits 7..4 are stored; bits 3..0 read as 0, and codes 6 and 7 read as 0x00.
- R3: Mode field of timer 0 is mode byte bits [3:0] and of timer 1 bits [7:4]; within a field, bits [1:0] are the mode, bit 2 the external select and bit 3 the gate. Control bit 4 is run0, bit 5 flag0, bit 6 run1, bit 7 flag1. A timer advances only on a tick with run=1, gate=0 and external select=0; otherwise it holds.
- R4: Mode 0 counts the 13-bit value {high, low[4:0]}; low[7:5] are never changed; the wrap from all ones to zero sets the flag.
- R5: Mode 1 counts the 16-bit value {high, low}; the wrap to zero sets the flag.
- R6: Mode 2 increments only the low byte; when it is 0xFF the next step loads it from the high byte and sets the flag.
- R7: Timer 0 in mode 3: its low byte is an 8-bit counter under timer 0's own run, gate and select bits, and its wrap sets flag0.
- R8: Timer 0 in mode 3: its high byte is an 8-bit counter that advances on every tick while run1 is set, whatever timer 0's own bits are, and its wrap sets flag1.
- R9: Timer 1 in mode 3 holds both of its bytes even while run1 is set.
- R10: A write to a count byte in the same cycle as an increment stores the written value.
- R11: A flag stays set until a control write puts 0 in it or an `ovf_clr` pulse clears it; an overflow in the same cycle as either leaves it set.
- R12: `ovf_flag[0]` and `ovf_flag[1]` always equal control bits 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe, one count step per high cycle |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Register code of the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register code of the read |
| rd_data | output | 8 | Read data, combinational |
| ovf_clr | input | 2 | One-cycle flag clear per timer |
| ovf_flag | output | 2 | Overflow flag per timer |

## Verification
Each mode is run from a preload just below its wrap point. The 13-bit and 16-bit modes show whether the carry reaches the high byte and whether the upper low bits are kept, and the reload mode shows whether the wrap copies the high byte or simply rolls to zero. Runs with the gate bit or the external select bit set tell a correct enable apart from one that looks only at the run bit. The split-mode runs clear timer 0's run bit or set its gate while run1 is set. These runs separate the two halves' enables and show which flag each half raises. Timer 1 in mode 3 must stay frozen. Directed cases collide a bus write with a tick, and an overflow with a clear pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR = 2;
  localparam int FLD_W   = 4;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    MD_PRESCALE = 2'd0,
    MD_WIDE     = 2'd1,
    MD_RELOAD   = 2'd2,
    MD_SPLIT    = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_field_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_LO0  = 3'd0,
    SEL_HI0  = 3'd1,
    SEL_LO1  = 3'd2,
    SEL_HI1  = 3'd3,
    SEL_MODE = 3'd4,
    SEL_CTRL = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 5,
  parameter bit SPLIT = 1'b0
) (
  input  logic             tick,
  input  logic             run,
  input  logic             hi_run,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] lo_q,
  input  logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_d,
  output logic [CNT_W-1:0] hi_d,
  output logic             wrap_own,
  output logic             wrap_lent
);
  localparam int PS_W   = CNT_W + PRE_W;
  localparam int WIDE_W = 2 * CNT_W;

  logic              step;
  logic              hi_step;
  logic [PS_W-1:0]   ps_cur;
  logic [PS_W-1:0]   ps_sum;
  logic [WIDE_W-1:0] wide_sum;
  logic [CNT_W-1:0]  lo_inc;
  logic [CNT_W-1:0]  hi_inc;

  assign step     = tick & run;
  assign hi_step  = tick & hi_run;
  assign ps_cur   = {hi_q, lo_q[PRE_W-1:0]};
  assign ps_sum   = ps_cur + PS_W'(1);
  assign wide_sum = {hi_q, lo_q} + WIDE_W'(1);
  assign lo_inc   = lo_q + CNT_W'(1);
  assign hi_inc   = hi_q + CNT_W'(1);

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    wrap_own  = 1'b0;
    wrap_lent = 1'b0;
    unique case (mode)
      MD_PRESCALE: if (step) begin
        lo_d     = {lo_q[CNT_W-1:PRE_W], ps_sum[PRE_W-1:0]};
        hi_d     = ps_sum[PS_W-1:PRE_W];
        wrap_own = &ps_cur;
      end
      MD_WIDE: if (step) begin
        {hi_d, lo_d} = wide_sum;
        wrap_own     = &{hi_q, lo_q};
      end
      MD_RELOAD: if (step) begin
        if (&lo_q) begin
          lo_d     = hi_q;
          wrap_own = 1'b1;
        end else begin
          lo_d = lo_inc;
        end
      end
      MD_SPLIT: if (SPLIT) begin
        if (step) begin
          lo_d     = lo_inc;
          wrap_own = &lo_q;
        end
        if (hi_step) begin
          hi_d      = hi_inc;
          wrap_lent = &hi_q;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic [NUM_TMR-1:0] ovf_clr,
  output logic [NUM_TMR-1:0] ovf_flag
);
  localparam int MODE_W   = NUM_TMR * FLD_W;
  localparam int RUN_BASE = 4;

  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_lo, cnt_hi, lo_nx, hi_nx;
  logic [MODE_W-1:0]             mode_r;
  logic [NUM_TMR-1:0]            run_r, flag_r;
  logic [NUM_TMR-1:0]            run_ok, wrap_own, wrap_lent, flag_set;
  logic [NUM_TMR-1:0]            lo_wr, hi_wr;
  logic                          ctrl_wr;
  logic [CNT_W-1:0]              ctrl_rd;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tmr_field_t fld;
    assign fld       = mode_r[FLD_W*g +: FLD_W];
    assign run_ok[g] = run_r[g] & ~fld.gate & ~fld.ext_sel;
    assign lo_wr[g]  = wr_en && (wr_sel == SEL_W'(2*g));
    assign hi_wr[g]  = wr_en && (wr_sel == SEL_W'(2*g+1));
    // the split high half of a timer reports to the next timer's flag
    assign flag_set[g] = wrap_own[g] | wrap_lent[(g+NUM_TMR-1)%NUM_TMR];

    tmr_step #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SPLIT(g == 0)) u_step (
      .tick     (tick),
      .run      (run_ok[g]),
      .hi_run   (run_r[(g+1)%NUM_TMR]),
      .mode     (fld.mode),
      .lo_q     (cnt_lo[g]),
      .hi_q     (cnt_hi[g]),
      .lo_d     (lo_nx[g]),
      .hi_d     (hi_nx[g]),
      .wrap_own (wrap_own[g]),
      .wrap_lent(wrap_lent[g])
    );

    // R10: bus write beats the count step
    p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr[g] |=> cnt_lo[g] == $past(wr_data));
    // R11: flag holds without a clear source
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_r[g] && !ctrl_wr && !ovf_clr[g] |=> flag_r[g]);
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr[g] && !ctrl_wr && !flag_set[g] |=> !flag_r[g]);
    // R3: no tick and no write leaves the count alone
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr_en |=> $stable(cnt_lo[g]) && $stable(cnt_hi[g]));
    // R6: reload copies the old high byte and raises the flag
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick && run_ok[g] && fld.mode == MD_RELOAD && (&cnt_lo[g]) && !lo_wr[g]
      |=> cnt_lo[g] == $past(cnt_hi[g]) && flag_r[g]);
    if (g != 0) begin : g_frz
      // R9: a non-split timer in mode 3 is frozen
      p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fld.mode == MD_SPLIT && !lo_wr[g] && !hi_wr[g]
        |=> $stable(cnt_lo[g]) && $stable(cnt_hi[g]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      mode_r <= '0;
      run_r  <= '0;
      flag_r <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_MODE) mode_r <= wr_data[MODE_W-1:0];
      for (int g = 0; g < NUM_TMR; g++) begin
        cnt_lo[g] <= lo_wr[g] ? wr_data : lo_nx[g];
        cnt_hi[g] <= hi_wr[g] ? wr_data : hi_nx[g];
        if (ctrl_wr) begin
          run_r[g]  <= wr_data[RUN_BASE + 2*g];
          flag_r[g] <= wr_data[RUN_BASE + 2*g + 1] | flag_set[g];
        end else begin
          flag_r[g] <= (flag_r[g] & ~ovf_clr[g]) | flag_set[g];
        end
      end
    end
  end

  always_comb begin
    ctrl_rd = '0;
    for (int g = 0; g < NUM_TMR; g++) begin
      ctrl_rd[RUN_BASE + 2*g]     = run_r[g];
      ctrl_rd[RUN_BASE + 2*g + 1] = flag_r[g];
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_LO0:  rd_data = cnt_lo[0];
      SEL_HI0:  rd_data = cnt_hi[0];
      SEL_LO1:  rd_data = cnt_lo[1];
      SEL_HI1:  rd_data = cnt_hi[1];
      SEL_MODE: rd_data = CNT_W'(mode_r);
      SEL_CTRL: rd_data = ctrl_rd;
      default:  rd_data = '0;
    endcase
  end

  assign ovf_flag = flag_r;
endmodule

// File: tb/tb_tmr_dual.sv
module tb_tmr_dual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] ovf_clr = '0;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_dual dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  // {timer, mode byte, control byte, low, high, ticks, exp low, exp high, exp control}
  localparam logic [71:0] VEC [11] = '{
    {8'd0, 8'h01, 8'h10, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 8'h30}, // R5
    {8'd0, 8'h00, 8'h10, 8'hFE, 8'hFF, 8'd3, 8'hE1, 8'h00, 8'h30}, // R4
    {8'd0, 8'h02, 8'h10, 8'hFD, 8'h80, 8'd4, 8'h81, 8'h80, 8'h30}, // R6
    {8'd0, 8'h09, 8'h10, 8'h10, 8'h00, 8'd5, 8'h10, 8'h00, 8'h10}, // R3 gate
    {8'd0, 8'h05, 8'h10, 8'h10, 8'h00, 8'd5, 8'h10, 8'h00, 8'h10}, // R3 select
    {8'd1, 8'h10, 8'h40, 8'hFF, 8'hFF, 8'd2, 8'h01, 8'h00, 8'hC0}, // R5 timer 1
    {8'd1, 8'h20, 8'h40, 8'hFF, 8'h33, 8'd2, 8'h34, 8'h33, 8'hC0}, // R6 timer 1
    {8'd1, 8'h30, 8'h40, 8'h12, 8'h34, 8'd6, 8'h12, 8'h34, 8'h40}, // R9
    {8'd0, 8'h33, 8'h50, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h02, 8'hF0}, // R7 R8
    {8'd0, 8'h33, 8'h40, 8'h05, 8'h10, 8'd4, 8'h05, 8'h14, 8'h40}, // R8 run0 off
    {8'd0, 8'h3B, 8'h50, 8'h05, 8'h10, 8'd2, 8'h05, 8'h12, 8'h50}  // R8 gate on
  };
  string tags [11] = '{"R5", "R4", "R6", "R3", "R3", "R5", "R6", "R9", "R7/R8", "R8", "R8"};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  initial begin
    logic [7:0] v, idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 unused codes
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v); chk("R1", v, 8'h00);
    end
    rd(3'd6, v); chk("R2", v, 8'h00);
    chk("R1", {6'd0, ovf_flag}, 8'h00);
    // R2 control low nibble and mode readback
    wr(3'd5, 8'h0F); rd(3'd5, v); chk("R2", v, 8'h00);
    wr(3'd4, 8'hA5); rd(3'd4, v); chk("R2", v, 8'hA5);

    for (int i = 0; i < 11; i++) begin
      idx = VEC[i][71:64];
      wr(3'd5, 8'h00);
      wr(3'd4, VEC[i][63:56]);
      wr(3'(2*idx), VEC[i][47:40]);
      wr(3'(2*idx+1), VEC[i][39:32]);
      wr(3'd5, VEC[i][55:48]);
      ticks(int'(VEC[i][31:24]));
      rd(3'(2*idx), v);   chk(tags[i], v, VEC[i][23:16]);
      rd(3'(2*idx+1), v); chk(tags[i], v, VEC[i][15:8]);
      rd(3'd5, v);        chk(tags[i], v, VEC[i][7:0]);
      chk("R12", {6'd0, ovf_flag}, {6'd0, VEC[i][7], VEC[i][5]});
    end

    // R10: write and tick in the same cycle
    wr(3'd5, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h10);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h55;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, v); chk("R10", v, 8'h55);
    rd(3'd1, v); chk("R10", v, 8'h00);
    ticks(1);
    rd(3'd0, v); chk("R10", v, 8'h56);

    // R11: sticky flag, clear pulse, set wins over clear
    wr(3'd5, 8'h00); wr(3'd4, 8'h02); wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
    wr(3'd5, 8'h10);
    ticks(4);
    rd(3'd0, v); chk("R6", v, 8'h03);
    rd(3'd5, v); chk("R11", v, 8'h30);
    @(negedge clk); ovf_clr = 2'b01;
    @(negedge clk); ovf_clr = 2'b00;
    rd(3'd5, v); chk("R11", v, 8'h10);
    chk("R12", {6'd0, ovf_flag}, 8'h00);
    wr(3'd0, 8'hFF);
    @(negedge clk); tick = 1'b1; ovf_clr = 2'b01;
    @(negedge clk); tick = 1'b0; ovf_clr = 2'b00;
    rd(3'd5, v); chk("R11", v, 8'h30);
    rd(3'd0, v); chk("R6", v, 8'h00);
    wr(3'd5, 8'h80);
    rd(3'd5, v); chk("R11", v, 8'h80);
    chk("R12", {6'd0, ovf_flag}, 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule